// File: doc/BRIEF.md
# Vectored interrupt entry controller

This block handles external interrupts for a 32-bit processor. It has three pieces of state: an interrupt-enable flag, a register that holds the saved program counter, and a 16-bit register that holds information about the source. The controller looks at the request line only while the core raises its instruction-boundary strobe, which marks the point where the next fetch would start. If a request is present and interrupts are enabled at that point, the controller takes the interrupt instead of letting the fetch proceed. It stores the current program counter and the source information, clears the enable flag, builds a vector address from the 8-bit source type, issues a program-counter load with that address, and raises acknowledge for one clock.

The core's decoder passes the interrupt-related instructions to the block as command codes on a command port. These commands are: return from interrupt, enable, disable, copying the saved state out to two register operands, and loading that state back from two operands. The block has no priority logic. When several devices request at once, external logic chooses one of them and presents its request, type and information.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: An interrupt is taken at a clock edge only when the boundary strobe, the request and the enable flag are all 1 before that edge. After the edge, `irq_ack_o` and `pc_load_en_o` are both 1. A boundary with no request does not take an interrupt.
- R2: When an interrupt is taken, `saved_pc_o` captures `pc_i` and `saved_info_o` captures `irq_info_i` at that same edge.
- R3: Taking an interrupt clears the enable flag. `irq_ack_o` stays high for exactly one clock for each interrupt taken.
- R4: The vector loaded on entry has bits 31..12 at zero, the source type in bits 11..4, and bits 3..0 at zero.
- R5: Command code 29 (return) does two things at the same edge: it drives `pc_load_o` with the saved PC, with `pc_load_en_o` high, and it sets the enable flag.
- R6: Command code 10 sets the enable flag. Command code 11 clears it.
- R7: Command code 16 (copy out) raises `save_valid_o` for one clock. During that clock, `save_a_o` holds the information register zero-extended to 32 bits, and `save_b_o` holds the saved PC.
- R8: Command code 17 (load back) writes `restore_info_i` into the information register and `restore_pc_i` into the saved-PC register.
- R9: A request that arrives while the enable flag is 0 is not remembered. It is taken at a later boundary only if it is still asserted once interrupts are enabled.
- R10: The asynchronous active-low reset clears the enable flag, the saved PC, the information register and every output.
- R11: When a command arrives at the same edge at which an interrupt is taken, the interrupt wins and the command has no effect.
- R12: A command with `op_valid_i` low, or with any code not listed above, has no effect. `pc_load_o` reads zero whenever `pc_load_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Request from the selected external source |
| irq_type_i | input | 8 | Source type code that selects the vector |
| irq_info_i | input | 16 | Source information to be saved |
| pc_i | input | 32 | Current program counter |
| boundary_i | input | 1 | Instruction-boundary strobe |
| op_valid_i | input | 1 | Command strobe |
| op_code_i | input | 5 | Command code |
| restore_info_i | input | 16 | Operand used by load back for the information register |
| restore_pc_i | input | 32 | Operand used by load back for the saved PC |
| pc_load_o | output | 32 | New program counter value |
| pc_load_en_o | output | 1 | Program counter load strobe |
| irq_ack_o | output | 1 | Acknowledge pulse |
| ie_o | output | 1 | Enable flag |
| saved_pc_o | output | 32 | Saved-PC register |
| saved_info_o | output | 16 | Information register |
| save_valid_o | output | 1 | Copy-out result valid |
| save_a_o | output | 32 | Information register, zero-extended |
| save_b_o | output | 32 | Saved PC, copy-out operand |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit type placed at bit 4, and 16-bit information. With these values the vector can be checked exactly against its zero fields, including the all-ones type that produces 0xFF0. The directed sequences cover several cases: a request that is still held across a disable-to-enable transition, a request that is dropped before enable, a load-back command that collides with interrupt entry, and an asynchronous reset in the middle of a run. A behavioural model follows every register on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned OP_W = 5;

  localparam logic [OP_W-1:0] OPC_EI      = 5'd10;
  localparam logic [OP_W-1:0] OPC_DI      = 5'd11;
  localparam logic [OP_W-1:0] OPC_SAVE    = 5'd16;
  localparam logic [OP_W-1:0] OPC_RESTORE = 5'd17;
  localparam logic [OP_W-1:0] OPC_RTI     = 5'd29;

  typedef struct packed {
    logic rti;
    logic ei;
    logic di;
    logic save;
    logic restore;
  } irq_cmd_t;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] code_i,
  output irq_cmd_t        cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (valid_i) begin
      case (code_i)
        OPC_RTI:     cmd_o.rti     = 1'b1;
        OPC_EI:      cmd_o.ei      = 1'b1;
        OPC_DI:      cmd_o.di      = 1'b1;
        OPC_SAVE:    cmd_o.save    = 1'b1;
        OPC_RESTORE: cmd_o.restore = 1'b1;
        default:     cmd_o         = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned TYPE_W  = 8,
  parameter int unsigned VEC_LSB = 4
) (
  input  logic [TYPE_W-1:0] type_i,
  output logic [XLEN-1:0]   vec_o
);
  localparam int unsigned VEC_MSB = VEC_LSB + TYPE_W - 1;

  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b >= VEC_LSB && b <= VEC_MSB) begin : g_type
      assign vec_o[b] = type_i[b-VEC_LSB];
    end else begin : g_zero
      assign vec_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned INFO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              set_ie_i,
  input  logic              clr_ie_i,
  input  logic              restore_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [XLEN-1:0]   restore_pc_i,
  input  logic [INFO_W-1:0] restore_info_i,
  output logic              ie_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [INFO_W-1:0] saved_info_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o <= 1'b0;
    end else if (take_i) begin
      ie_o <= 1'b0;
    end else if (set_ie_i) begin
      ie_o <= 1'b1;
    end else if (clr_ie_i) begin
      ie_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_pc_o   <= '0;
      saved_info_o <= '0;
    end else if (take_i) begin
      saved_pc_o   <= pc_i;
      saved_info_o <= info_i;
    end else if (restore_i) begin
      saved_pc_o   <= restore_pc_i;
      saved_info_o <= restore_info_i;
    end
  end
endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned TYPE_W  = 8,
  parameter int unsigned INFO_W  = 16,
  parameter int unsigned VEC_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [TYPE_W-1:0] irq_type_i,
  input  logic [INFO_W-1:0] irq_info_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              boundary_i,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_code_i,
  input  logic [INFO_W-1:0] restore_info_i,
  input  logic [XLEN-1:0]   restore_pc_i,
  output logic [XLEN-1:0]   pc_load_o,
  output logic              pc_load_en_o,
  output logic              irq_ack_o,
  output logic              ie_o,
  output logic [XLEN-1:0]   saved_pc_o,
  output logic [INFO_W-1:0] saved_info_o,
  output logic              save_valid_o,
  output logic [XLEN-1:0]   save_a_o,
  output logic [XLEN-1:0]   save_b_o
);
  localparam int unsigned PAD_W = XLEN - INFO_W;

  irq_cmd_t        cmd_raw;
  irq_cmd_t        cmd;
  logic            take;
  logic [XLEN-1:0] vec;

  irq_cmd_decode u_dec (
    .valid_i (op_valid_i),
    .code_i  (op_code_i),
    .cmd_o   (cmd_raw)
  );

  // interrupt entry owns the boundary; a coincident command is dropped
  assign take = boundary_i & irq_req_i & ie_o;
  assign cmd  = take ? '0 : cmd_raw;

  irq_vector_gen #(
    .XLEN    (XLEN),
    .TYPE_W  (TYPE_W),
    .VEC_LSB (VEC_LSB)
  ) u_vec (
    .type_i (irq_type_i),
    .vec_o  (vec)
  );

  irq_state_regs #(
    .XLEN   (XLEN),
    .INFO_W (INFO_W)
  ) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .take_i         (take),
    .set_ie_i       (cmd.ei | cmd.rti),
    .clr_ie_i       (cmd.di),
    .restore_i      (cmd.restore),
    .pc_i           (pc_i),
    .info_i         (irq_info_i),
    .restore_pc_i   (restore_pc_i),
    .restore_info_i (restore_info_i),
    .ie_o           (ie_o),
    .saved_pc_o     (saved_pc_o),
    .saved_info_o   (saved_info_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_load_o    <= '0;
      pc_load_en_o <= 1'b0;
      irq_ack_o    <= 1'b0;
    end else begin
      irq_ack_o    <= take;
      pc_load_en_o <= take | cmd.rti;
      if (take)         pc_load_o <= vec;
      else if (cmd.rti) pc_load_o <= saved_pc_o;
      else              pc_load_o <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_valid_o <= 1'b0;
      save_a_o     <= '0;
      save_b_o     <= '0;
    end else begin
      save_valid_o <= cmd.save;
      save_a_o     <= cmd.save ? {{PAD_W{1'b0}}, saved_info_o} : '0;
      save_b_o     <= cmd.save ? saved_pc_o : '0;
    end
  end
endmodule

// File: rtl/vectored_irq_ctrl_chk.sv
module vectored_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned TYPE_W  = 8,
  parameter int unsigned INFO_W  = 16,
  parameter int unsigned VEC_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_i,
  input logic [TYPE_W-1:0] irq_type_i,
  input logic [INFO_W-1:0] irq_info_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              boundary_i,
  input logic              op_valid_i,
  input logic [OP_W-1:0]   op_code_i,
  input logic [XLEN-1:0]   pc_load_o,
  input logic              pc_load_en_o,
  input logic              irq_ack_o,
  input logic              ie_o,
  input logic [XLEN-1:0]   saved_pc_o,
  input logic [INFO_W-1:0] saved_info_o,
  input logic              save_valid_o
);
  a_r1_ack_needs_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> $past(boundary_i && irq_req_i && ie_o));

  a_r2_state_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (saved_pc_o == $past(pc_i)) && (saved_info_o == $past(irq_info_i)));

  a_r3_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  a_r3_ack_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !ie_o);

  a_r4_vector_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> pc_load_en_o && (pc_load_o == (XLEN'($past(irq_type_i)) << VEC_LSB)));

  a_r5_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OPC_RTI && !(boundary_i && irq_req_i && ie_o))
      |=> ie_o && pc_load_en_o && (pc_load_o == $past(saved_pc_o)));

  a_r9_disabled_no_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_o |=> !irq_ack_o);

  a_r12_idle_pc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_en_o |-> (pc_load_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r10_reset_state: assert (!ie_o && !irq_ack_o && !pc_load_en_o && !save_valid_o
                                 && saved_pc_o == '0 && saved_info_o == '0);
    end
  end
endmodule

bind vectored_irq_ctrl vectored_irq_ctrl_chk #(
  .XLEN    (XLEN),
  .TYPE_W  (TYPE_W),
  .INFO_W  (INFO_W),
  .VEC_LSB (VEC_LSB)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_req_i    (irq_req_i),
  .irq_type_i   (irq_type_i),
  .irq_info_i   (irq_info_i),
  .pc_i         (pc_i),
  .boundary_i   (boundary_i),
  .op_valid_i   (op_valid_i),
  .op_code_i    (op_code_i),
  .pc_load_o    (pc_load_o),
  .pc_load_en_o (pc_load_en_o),
  .irq_ack_o    (irq_ack_o),
  .ie_o         (ie_o),
  .saved_pc_o   (saved_pc_o),
  .saved_info_o (saved_info_o),
  .save_valid_o (save_valid_o)
);

// File: tb/vectored_irq_ctrl_tb_top.sv
module vectored_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req = 1'b0;
  logic [7:0]  typ = '0;
  logic [15:0] info = '0;
  logic [31:0] pc = '0;
  logic        bnd = 1'b0;
  logic        opv = 1'b0;
  logic [4:0]  opc = '0;
  logic [15:0] r_info = '0;
  logic [31:0] r_pc = '0;

  logic [31:0] pc_load;
  logic        pc_load_en, ack, ie, save_valid;
  logic [31:0] saved_pc, save_a, save_b;
  logic [15:0] saved_info;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  vectored_irq_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_req_i (req), .irq_type_i (typ),
    .irq_info_i (info), .pc_i (pc), .boundary_i (bnd), .op_valid_i (opv),
    .op_code_i (opc), .restore_info_i (r_info), .restore_pc_i (r_pc),
    .pc_load_o (pc_load), .pc_load_en_o (pc_load_en), .irq_ack_o (ack),
    .ie_o (ie), .saved_pc_o (saved_pc), .saved_info_o (saved_info),
    .save_valid_o (save_valid), .save_a_o (save_a), .save_b_o (save_b)
  );

  // behavioural reference
  logic        m_ie, m_ack, m_en, m_sv;
  logic [31:0] m_spc, m_pcl, m_sa, m_sb;
  logic [15:0] m_info;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_ack = 0; m_en = 0; m_sv = 0;
      m_spc = 0; m_pcl = 0; m_sa = 0; m_sb = 0; m_info = 0;
    end else begin
      bit tk, rti, ei, di, sv, rs;
      logic [31:0] o_spc;
      logic [15:0] o_info;
      tk = bnd && req && m_ie;
      rti = opv && opc == 29 && !tk;
      ei  = opv && opc == 10 && !tk;
      di  = opv && opc == 11 && !tk;
      sv  = opv && opc == 16 && !tk;
      rs  = opv && opc == 17 && !tk;
      o_spc = m_spc; o_info = m_info;
      m_ack = tk;
      m_en  = tk || rti;
      m_pcl = tk ? {20'd0, typ, 4'd0} : (rti ? o_spc : 32'd0);
      m_sv  = sv;
      m_sa  = sv ? {16'd0, o_info} : 32'd0;
      m_sb  = sv ? o_spc : 32'd0;
      if (tk) m_ie = 0; else if (ei || rti) m_ie = 1; else if (di) m_ie = 0;
      if (tk) begin m_spc = pc; m_info = info; end
      else if (rs) begin m_spc = r_pc; m_info = r_info; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 model ack", 32'(ack), 32'(m_ack));
      chk("R1 model pc_load_en", 32'(pc_load_en), 32'(m_en));
      chk("R4 model pc_load", pc_load, m_pcl);
      chk("R6 model ie", 32'(ie), 32'(m_ie));
      chk("R2 model saved_pc", saved_pc, m_spc);
      chk("R2 model saved_info", 32'(saved_info), 32'(m_info));
      chk("R7 model save_valid", 32'(save_valid), 32'(m_sv));
      chk("R7 model save_a", save_a, m_sa);
      chk("R7 model save_b", save_b, m_sb);
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle();
    req = 0; bnd = 0; opv = 0; opc = '0;
  endtask

  task automatic cmd(logic [4:0] c);
    opv = 1; opc = c; cyc(); idle();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    #2 rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cmp_on = 1;
    cyc();
    // R10 reset state
    chk("R10 ie", 32'(ie), 0);
    chk("R10 saved_pc", saved_pc, 0);
    chk("R10 pc_load_en", 32'(pc_load_en), 0);

    cmd(5'd10);
    chk("R6 enable", 32'(ie), 1);

    bnd = 1; cyc(); idle();
    chk("R1 boundary without request", 32'(ack), 0);

    pc = 32'h1234_5678; typ = 8'hA5; info = 16'hBEEF; req = 1; bnd = 1;
    cyc(); idle();
    chk("R1 ack", 32'(ack), 1);
    chk("R1 pc_load_en", 32'(pc_load_en), 1);
    chk("R4 vector", pc_load, 32'h0000_0A50);
    chk("R2 saved_pc", saved_pc, 32'h1234_5678);
    chk("R2 saved_info", 32'(saved_info), 32'h0000_BEEF);
    chk("R3 ie cleared", 32'(ie), 0);
    cyc();
    chk("R3 ack one clock", 32'(ack), 0);

    cmd(5'd16);
    chk("R7 save_valid", 32'(save_valid), 1);
    chk("R7 save_a", save_a, 32'h0000_BEEF);
    chk("R7 save_b", save_b, 32'h1234_5678);
    cyc();
    chk("R7 save_valid drops", 32'(save_valid), 0);

    r_info = 16'h1234; r_pc = 32'hCAFE_0000;
    cmd(5'd17);
    chk("R8 info loaded", 32'(saved_info), 32'h0000_1234);
    chk("R8 pc loaded", saved_pc, 32'hCAFE_0000);

    cmd(5'd29);
    chk("R5 pc_load_en", 32'(pc_load_en), 1);
    chk("R5 pc_load", pc_load, 32'hCAFE_0000);
    chk("R5 ie set", 32'(ie), 1);

    cmd(5'd11);
    chk("R6 disable", 32'(ie), 0);

    // R9 held request crosses enable
    req = 1; bnd = 1; cyc();
    chk("R9 disabled no ack", 32'(ack), 0);
    bnd = 0; opv = 1; opc = 5'd10; cyc();
    chk("R9 still no ack", 32'(ack), 0);
    opv = 0; bnd = 1; pc = 32'h40; typ = 8'hFF; info = 16'h0001; cyc(); idle();
    chk("R9 held request taken", 32'(ack), 1);
    chk("R4 all-ones type", pc_load, 32'h0000_0FF0);

    // R9 dropped request not remembered
    req = 1; cyc(); idle();
    cmd(5'd10);
    bnd = 1; cyc(); idle();
    chk("R9 dropped request ignored", 32'(ack), 0);

    // R11 collision: load back loses to entry
    pc = 32'h0000_0ABC; typ = 8'h01; info = 16'h7777; req = 1; bnd = 1;
    opv = 1; opc = 5'd17; r_info = 16'h5555; r_pc = 32'hDEAD_BEEF;
    cyc(); idle();
    chk("R11 ack", 32'(ack), 1);
    chk("R11 saved_pc from entry", saved_pc, 32'h0000_0ABC);
    chk("R11 saved_info from entry", 32'(saved_info), 32'h0000_7777);

    // R12 ignored commands
    opv = 0; opc = 5'd10; cyc(); idle();
    chk("R12 no strobe", 32'(ie), 0);
    cmd(5'd5);
    chk("R12 unknown code ie", 32'(ie), 0);
    chk("R12 unknown code pc_load_en", 32'(pc_load_en), 0);
    chk("R12 pc_load zero", pc_load, 0);
    chk("R12 saved_pc kept", saved_pc, 32'h0000_0ABC);

    // R10 asynchronous reset mid-run
    cmd(5'd10);
    #2 rst_n = 0;
    #1;
    chk("R10 async ie", 32'(ie), 0);
    chk("R10 async saved_pc", saved_pc, 0);
    chk("R10 async saved_info", 32'(saved_info), 0);
    cyc();
    rst_n = 1;
    repeat (2) cyc();
    summary();
  end
endmodule